// File: doc/BRIEF.md
# ROM Patch Overlay Controller

This block sits between a processor's 16-bit byte address bus and a set of fixed program ROMs. It splits the 64 KiB space into four 16 KiB regions and produces chip selects for the three on-board ROM regions. The lowest region belongs to external cartridges and selects nothing on the board. Inside the second region a 1 KiB window is carved out for a patch ROM. That patch ROM is two byte lanes, even and odd. Each lane is either 256 or 512 bytes deep; a 256-byte part repeats across both halves of the window.

A table of patch entries repairs individual bytes in the fixed ROMs. Each entry holds a valid flag, a full byte address and a replacement byte. A read that hits a valid entry returns the replacement byte in the same cycle as an ordinary read. A longer repair uses a few entries that spell out a jump into the patch window, where the corrected code lives. One configuration input turns the whole patch mechanism off. The full second region then reads from its main ROM and no substitution happens.

A three-state controller runs the table. After reset, CLEAR sweeps every entry to invalid, one entry per cycle. The transition SWEEP_DONE leaves CLEAR after the last entry and goes to READ if a read is active, otherwise to IDLE. From IDLE, BUS_BUSY goes to READ when a read starts. From READ, BUS_FREE returns to IDLE in the first cycle without a read. Table writes are taken only in IDLE with no read on the bus.

Top module: `rom_patch_overlay`

## Requirements
- R1: Chip selects are active only while `bus_rd` is 1. Addresses 8000-BFFF assert `cs_rom_mid` and C000-FFFF assert `cs_rom_high`. Addresses 0000-3FFF assert no select and return `rd_data` = FF. At most one select is high at any time, and `rd_data` is FF whenever `bus_rd` is 0.
- R2: When `cfg_patch_off` is 0, addresses whose upper six bits are 010001 (4400-47FF) assert `cs_patch` and return `patch_rd_data`. Addresses 4000-43FF and 4800-7FFF assert `cs_rom_low`.
- R3: When `cfg_patch_off` is 1, all of 4000-7FFF asserts `cs_rom_low`. No read anywhere is substituted from the table; every on-board ROM read returns `main_rd_data`.
- R4: `rom_word` carries the byte offset within the 16 KiB region divided by two, and `rom_odd` carries address bit 0. For example, 4400 gives word 200.
- R5: `patch_lane_addr` carries address bits 9..1 and `patch_odd` carries bit 0. When `cfg_small_lanes` is 1, bit 8 of `patch_lane_addr` is forced to 0, so 4600-47FF reads the same lane words as 4400-45FF.
- R6: A read on a main-ROM select whose address equals the address of a valid entry returns that entry's byte in the same cycle. Cartridge-region addresses and window addresses are never substituted.
- R7: When several valid entries hold the same address, the entry with the lowest index supplies the byte.
- R8: A main-ROM read that matches no valid entry returns `main_rd_data` unchanged.
- R9: For 16 cycles after reset `tbl_ready` is 0: the sweep invalidates entries 0 to 15, no substitution happens and no write is taken. After the sweep `tbl_ready` stays 1, and entries loaded before the reset no longer match.
- R10: A table write (`tbl_wr_en`) is taken, and `tbl_wr_ack` is 1, only when `bus_rd` is 0 in that cycle and also in the previous cycle. Any other write is dropped without changing the table.
- R11: Writing an entry with `tbl_wr_valid` = 0 removes it. Reads at its address then fall back to the next matching entry or to `main_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_patch_off | input | 1 | 1 turns off the patch window and the table |
| cfg_small_lanes | input | 1 | 1 selects 256-byte patch lanes (mirrored window) |
| bus_addr | input | 16 | Byte address of the current read |
| bus_rd | input | 1 | Read strobe |
| main_rd_data | input | 8 | Byte returned by the selected main ROM |
| patch_rd_data | input | 8 | Byte returned by the selected patch lane |
| tbl_wr_en | input | 1 | Table write request |
| tbl_wr_idx | input | 4 | Entry index to write |
| tbl_wr_valid | input | 1 | Valid flag to store |
| tbl_wr_addr | input | 16 | Target address to store |
| tbl_wr_data | input | 8 | Replacement byte to store |
| tbl_ready | output | 1 | Sweep finished; table active |
| tbl_wr_ack | output | 1 | The write request is taken this cycle |
| cs_rom_low | output | 1 | Select for main ROM of 4000-7FFF |
| cs_rom_mid | output | 1 | Select for ROM of 8000-BFFF |
| cs_rom_high | output | 1 | Select for ROM of C000-FFFF |
| cs_patch | output | 1 | Select for the patch window |
| rom_word | output | 13 | Word offset inside the selected region |
| rom_odd | output | 1 | Odd byte lane of the main ROM |
| patch_lane_addr | output | 9 | Word address inside the patch lanes |
| patch_odd | output | 1 | Odd patch lane select |
| rd_data | output | 8 | Byte returned to the bus |

## Verification
Two cases are hard to reach from the ports. One is the turnaround cycle just after a read: the bus is quiet but the controller is still in READ, so a write there must be dropped. The stimulus places writes in exactly that cycle and in the following one. The other is a second reset with a full table. Stale entries then sit in storage while the sweep runs. The stimulus loads several entries, resets again, and reads those addresses during and after the sweep. A reference model checks every output on every cycle.

// File: rtl/rpo_pkg.sv
package rpo_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2
    } ctrl_state_t;

    // 16 KiB region selected by the two top address bits
    typedef enum logic [1:0] {
        RG_CART = 2'd0,
        RG_LOW  = 2'd1,
        RG_MID  = 2'd2,
        RG_HIGH = 2'd3
    } region_t;

endpackage

// File: rtl/rpo_ctrl.sv
module rpo_ctrl
    import rpo_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             wr_req,
    output logic             ready,
    output logic             wr_ok,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    ctrl_state_t      state_q;
    ctrl_state_t      state_d;
    logic [IDX_W-1:0] sweep_q;

    // state register and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                sweep_q <= sweep_q + 1'b1;
            end
        end
    end

    // transitions: SWEEP_DONE, BUS_BUSY, BUS_FREE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (sweep_q == LAST_IDX) begin
                    state_d = bus_rd ? ST_READ : ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (bus_rd) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (!bus_rd) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        wr_ok   = 1'b0;
        clr_en  = 1'b0;
        clr_idx = sweep_q;
        unique case (state_q)
            ST_CLEAR: clr_en = 1'b1;
            ST_IDLE: begin
                ready = 1'b1;
                wr_ok = wr_req && !bus_rd;
            end
            ST_READ:  ready = 1'b1;
            default:  clr_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/rpo_decode.sv
module rpo_decode
    import rpo_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4400,
    parameter int                WIN_BYTES = 1024
) (
    input  logic                          addr_rd,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          patch_off,
    input  logic                          small_lanes,
    output logic                          cs_low,
    output logic                          cs_mid,
    output logic                          cs_high,
    output logic                          cs_win,
    output logic [ADDR_W-3:0]             rom_word,
    output logic                          rom_odd,
    output logic [$clog2(WIN_BYTES)-2:0]  lane_addr,
    output logic                          lane_odd
);

    localparam int WIN_BITS = $clog2(WIN_BYTES);
    localparam int LANE_AW  = WIN_BITS - 1;

    region_t rg;
    logic    in_win;

    assign rg     = region_t'(addr[ADDR_W-1 -: 2]);
    assign in_win = !patch_off && (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    always_comb begin
        cs_low  = 1'b0;
        cs_mid  = 1'b0;
        cs_high = 1'b0;
        cs_win  = 1'b0;
        unique case (rg)
            RG_CART: ;
            RG_LOW: begin
                if (in_win) cs_win = addr_rd;
                else        cs_low = addr_rd;
            end
            RG_MID:  cs_mid  = addr_rd;
            RG_HIGH: cs_high = addr_rd;
            default: ;
        endcase
    end

    // byte lanes: bit 0 picks odd/even, remaining bits form the word index
    assign rom_word = addr[ADDR_W-3:1];
    assign rom_odd  = addr[0];
    assign lane_odd = addr[0];

    always_comb begin
        lane_addr = addr[WIN_BITS-1:1];
        if (small_lanes) begin
            lane_addr[LANE_AW-1] = 1'b0;
        end
    end

endmodule

// File: rtl/rpo_table.sv
module rpo_table #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic              wvalid,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);

    logic [ENTRIES-1:0] match;
    logic [DATA_W-1:0]  ent_byte [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic              v_q;
        logic [ADDR_W-1:0] a_q;
        logic [DATA_W-1:0] d_q;

        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g))) begin
                v_q <= wvalid;
                a_q <= waddr;
                d_q <= wdata;
            end
        end

        assign match[g]    = v_q && (a_q == look_addr);
        assign ent_byte[g] = d_q;
    end

    // lowest index wins
    always_comb begin
        hit      = |match;
        hit_data = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_data = ent_byte[i];
            end
        end
    end

endmodule

// File: rtl/rom_patch_overlay.sv
module rom_patch_overlay #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                ENTRIES   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4400,
    parameter int                WIN_BYTES = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_patch_off,
    input  logic                         cfg_small_lanes,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_rd,
    input  logic [DATA_W-1:0]            main_rd_data,
    input  logic [DATA_W-1:0]            patch_rd_data,
    input  logic                         tbl_wr_en,
    input  logic [$clog2(ENTRIES)-1:0]   tbl_wr_idx,
    input  logic                         tbl_wr_valid,
    input  logic [ADDR_W-1:0]            tbl_wr_addr,
    input  logic [DATA_W-1:0]            tbl_wr_data,
    output logic                         tbl_ready,
    output logic                         tbl_wr_ack,
    output logic                         cs_rom_low,
    output logic                         cs_rom_mid,
    output logic                         cs_rom_high,
    output logic                         cs_patch,
    output logic [ADDR_W-3:0]            rom_word,
    output logic                         rom_odd,
    output logic [$clog2(WIN_BYTES)-2:0] patch_lane_addr,
    output logic                         patch_odd,
    output logic [DATA_W-1:0]            rd_data
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;
    logic              t_we;
    logic [IDX_W-1:0]  t_idx;
    logic              t_valid;
    logic              hit;
    logic [DATA_W-1:0] hit_data;
    logic              main_sel;
    logic              subst_en;

    rpo_ctrl #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rd  (bus_rd),
        .wr_req  (tbl_wr_en),
        .ready   (tbl_ready),
        .wr_ok   (tbl_wr_ack),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    rpo_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_decode (
        .addr_rd     (bus_rd),
        .addr        (bus_addr),
        .patch_off   (cfg_patch_off),
        .small_lanes (cfg_small_lanes),
        .cs_low      (cs_rom_low),
        .cs_mid      (cs_rom_mid),
        .cs_high     (cs_rom_high),
        .cs_win      (cs_patch),
        .rom_word    (rom_word),
        .rom_odd     (rom_odd),
        .lane_addr   (patch_lane_addr),
        .lane_odd    (patch_odd)
    );

    // the sweep takes the single write port while it runs
    assign t_we    = clr_en || tbl_wr_ack;
    assign t_idx   = clr_en ? clr_idx : tbl_wr_idx;
    assign t_valid = clr_en ? 1'b0 : tbl_wr_valid;

    rpo_table #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_table (
        .clk       (clk),
        .we        (t_we),
        .widx      (t_idx),
        .wvalid    (t_valid),
        .waddr     (tbl_wr_addr),
        .wdata     (tbl_wr_data),
        .look_addr (bus_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    assign main_sel = cs_rom_low || cs_rom_mid || cs_rom_high;
    assign subst_en = tbl_ready && !cfg_patch_off && main_sel && hit;

    always_comb begin
        rd_data = '1;
        if (cs_patch) begin
            rd_data = patch_rd_data;
        end else if (subst_en) begin
            rd_data = hit_data;
        end else if (main_sel) begin
            rd_data = main_rd_data;
        end
    end

endmodule

// File: rtl/rom_patch_overlay_chk.sv
module rom_patch_overlay_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4400,
    parameter int                WIN_BYTES = 1024
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_patch_off,
    input logic                         cfg_small_lanes,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_rd,
    input logic [DATA_W-1:0]            main_rd_data,
    input logic [DATA_W-1:0]            patch_rd_data,
    input logic                         tbl_ready,
    input logic                         tbl_wr_ack,
    input logic                         cs_rom_low,
    input logic                         cs_rom_mid,
    input logic                         cs_rom_high,
    input logic                         cs_patch,
    input logic [$clog2(WIN_BYTES)-2:0] patch_lane_addr,
    input logic [DATA_W-1:0]            rd_data
);

    localparam int WIN_BITS = $clog2(WIN_BYTES);

    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_rom_low, cs_rom_mid, cs_rom_high, cs_patch}));

    p_cart_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1 -: 2] == 2'b00) |->
            (!cs_rom_low && !cs_rom_mid && !cs_rom_high && !cs_patch && rd_data == '1));

    p_window_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_patch_off && bus_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS])
            |-> (cs_patch && !cs_rom_low));

    p_off_no_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_patch_off |-> !cs_patch);

    p_off_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_patch_off && (cs_rom_low || cs_rom_mid || cs_rom_high)) |-> (rd_data == main_rd_data));

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_patch && cfg_small_lanes) |-> !patch_lane_addr[WIN_BITS-2]);

    p_window_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_patch |-> (rd_data == patch_rd_data));

    p_sweep_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_ready |-> !tbl_wr_ack);

    p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_ready |=> tbl_ready);

    p_ack_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_ack |-> (!bus_rd && !$past(bus_rd)));

endmodule

bind rom_patch_overlay rom_patch_overlay_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_patch_off   (cfg_patch_off),
    .cfg_small_lanes (cfg_small_lanes),
    .bus_addr        (bus_addr),
    .bus_rd          (bus_rd),
    .main_rd_data    (main_rd_data),
    .patch_rd_data   (patch_rd_data),
    .tbl_ready       (tbl_ready),
    .tbl_wr_ack      (tbl_wr_ack),
    .cs_rom_low      (cs_rom_low),
    .cs_rom_mid      (cs_rom_mid),
    .cs_rom_high     (cs_rom_high),
    .cs_patch        (cs_patch),
    .patch_lane_addr (patch_lane_addr),
    .rd_data         (rd_data)
);

// File: tb/test_rom_patch_overlay.sv
module test_rom_patch_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_patch_off = 1'b0;
    logic        cfg_small_lanes = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 1'b0;
    logic [7:0]  main_rd_data;
    logic [7:0]  patch_rd_data;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_idx = 4'd0;
    logic        tbl_wr_valid = 1'b0;
    logic [15:0] tbl_wr_addr = 16'h0000;
    logic [7:0]  tbl_wr_data = 8'h00;
    logic        tbl_ready;
    logic        tbl_wr_ack;
    logic        cs_rom_low, cs_rom_mid, cs_rom_high, cs_patch;
    logic [12:0] rom_word;
    logic        rom_odd;
    logic [8:0]  patch_lane_addr;
    logic        patch_odd;
    logic [7:0]  rd_data;

    always #10 clk = ~clk;  // 50 MHz

    // ROM contents stand-ins, derived from the address
    assign main_rd_data  = bus_addr[7:0] ^ 8'h3C;
    assign patch_rd_data = bus_addr[7:0] ^ 8'hC3;

    rom_patch_overlay i_rom_patch_overlay (
        .clk(clk), .rst_n(rst_n),
        .cfg_patch_off(cfg_patch_off), .cfg_small_lanes(cfg_small_lanes),
        .bus_addr(bus_addr), .bus_rd(bus_rd),
        .main_rd_data(main_rd_data), .patch_rd_data(patch_rd_data),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .tbl_ready(tbl_ready), .tbl_wr_ack(tbl_wr_ack),
        .cs_rom_low(cs_rom_low), .cs_rom_mid(cs_rom_mid), .cs_rom_high(cs_rom_high),
        .cs_patch(cs_patch), .rom_word(rom_word), .rom_odd(rom_odd),
        .patch_lane_addr(patch_lane_addr), .patch_odd(patch_odd), .rd_data(rd_data)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R9";

    // behavioural reference model
    int        m_state;   // 0 sweep, 1 idle, 2 read
    int        m_cnt;
    bit        m_v [16];
    int        m_a [16];
    int        m_d [16];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int  a   = int'(bus_addr);
        int  rg  = a >> 14;
        bit  win = ((a >> 10) == 'h11) && !cfg_patch_off;
        int  e_cs;
        int  e_data;
        int  e_lane;
        bit  e_ack;
        bit  found = 0;
        e_cs = 0;
        if (bus_rd) begin
            if (rg == 1 && win)  e_cs = 1;
            if (rg == 1 && !win) e_cs = 8;
            if (rg == 2)         e_cs = 4;
            if (rg == 3)         e_cs = 2;
        end
        e_data = 'hFF;
        if (bus_rd && rg != 0) begin
            if (e_cs == 1) e_data = int'(patch_rd_data);
            else begin
                e_data = int'(main_rd_data);
                if (m_state != 0 && !cfg_patch_off) begin
                    for (int i = 0; i < 16; i++) begin
                        if (!found && m_v[i] && m_a[i] == a) begin
                            e_data = m_d[i];
                            found = 1;
                        end
                    end
                end
            end
        end
        e_ack = tbl_wr_en && (m_state == 1) && !bus_rd;
        e_lane = (a & 'h3FF) >> 1;
        if (cfg_small_lanes) e_lane = e_lane % 256;
        chk({cs_rom_low, cs_rom_mid, cs_rom_high, cs_patch} == 4'(e_cs), "chip selects",
            int'({cs_rom_low, cs_rom_mid, cs_rom_high, cs_patch}), e_cs);
        chk(int'(rd_data) == e_data, "rd_data", int'(rd_data), e_data);
        chk(tbl_ready == (m_state != 0), "tbl_ready", int'(tbl_ready), int'(m_state != 0));
        chk(tbl_wr_ack == e_ack, "tbl_wr_ack", int'(tbl_wr_ack), int'(e_ack));
        if (bus_rd) begin
            chk(int'(rom_word) == ((a & 'h3FFF) >> 1), "rom_word", int'(rom_word), (a & 'h3FFF) >> 1);
            chk(rom_odd == a[0], "rom_odd", int'(rom_odd), a & 1);
            chk(int'(patch_lane_addr) == e_lane, "patch_lane_addr", int'(patch_lane_addr), e_lane);
            chk(patch_odd == a[0], "patch_odd", int'(patch_odd), a & 1);
        end
    endtask

    task automatic model_update();
        bit acc = tbl_wr_en && (m_state == 1) && !bus_rd;
        if (m_state == 0) begin
            m_v[m_cnt] = 0;
            if (m_cnt == 15) m_state = bus_rd ? 2 : 1;
            m_cnt = (m_cnt + 1) % 16;
        end else if (m_state == 1) begin
            if (acc) begin
                m_v[tbl_wr_idx] = tbl_wr_valid;
                m_a[tbl_wr_idx] = int'(tbl_wr_addr);
                m_d[tbl_wr_idx] = int'(tbl_wr_data);
            end
            if (bus_rd) m_state = 2;
        end else if (!bus_rd) begin
            m_state = 1;
        end
    endtask

    task automatic step(input logic [15:0] a, input logic rd);
        bus_addr = a;
        bus_rd   = rd;
        #5;
        compare();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        step(a, 1'b1);
    endtask

    task automatic wr(input int idx, input bit v, input logic [15:0] ad, input logic [7:0] d,
                      input logic [15:0] a, input logic r);
        tbl_wr_en    = 1'b1;
        tbl_wr_idx   = 4'(idx);
        tbl_wr_valid = v;
        tbl_wr_addr  = ad;
        tbl_wr_data  = d;
        step(a, r);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bus_rd = 1'b0;
        tbl_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        m_state = 0;
        m_cnt   = 0;
        rst_n   = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_a[i] = 0; m_d[i] = 0;
        end
        do_reset();

        // R9: sweep after reset; write attempt during sweep is dropped
        cur_req = "R9";
        wr(2, 1'b1, 16'h8010, 8'h99, 16'h0000, 1'b0);
        for (int i = 0; i < 17; i++) rd(16'h8010);
        step(16'h0000, 1'b0);

        // R1: region decode, cartridge region and idle bus
        cur_req = "R1";
        rd(16'h0000); rd(16'h3FFF); rd(16'h8000); rd(16'hBFFF);
        rd(16'hC000); rd(16'hFFFF); step(16'h9000, 1'b0);

        // R2: window carve-out in the low region
        cur_req = "R2";
        rd(16'h4000); rd(16'h43FF); rd(16'h4400); rd(16'h47FF);
        rd(16'h4800); rd(16'h7FFF);

        // R4 and R5: offsets and lane mirroring
        cur_req = "R4";
        rd(16'h4400); rd(16'h4401); rd(16'hC7FE);
        cur_req = "R5";
        rd(16'h4600); rd(16'h47FF);
        cfg_small_lanes = 1'b1;
        rd(16'h4600); rd(16'h47FF); rd(16'h4401);
        cfg_small_lanes = 1'b0;

        // R10: write in the turnaround cycle is dropped, same-cycle read drops it too
        cur_req = "R10";
        step(16'h0000, 1'b0);
        rd(16'h8123);
        wr(0, 1'b1, 16'h8123, 8'hAA, 16'h0000, 1'b0);
        wr(0, 1'b1, 16'h8123, 8'hAA, 16'h8123, 1'b1);
        step(16'h0000, 1'b0);
        rd(16'h8123);
        step(16'h0000, 1'b0);
        wr(0, 1'b1, 16'h8123, 8'hAA, 16'h0000, 1'b0);

        // R6: substitution, including a jump sequence and excluded areas
        cur_req = "R6";
        wr(1, 1'b1, 16'h4001, 8'h55, 16'h0000, 1'b0);
        wr(4, 1'b1, 16'hC200, 8'h4C, 16'h0000, 1'b0);
        wr(5, 1'b1, 16'hC201, 8'h00, 16'h0000, 1'b0);
        wr(6, 1'b1, 16'hC202, 8'h44, 16'h0000, 1'b0);
        wr(7, 1'b1, 16'h0100, 8'h11, 16'h0000, 1'b0);
        wr(8, 1'b1, 16'h4410, 8'h22, 16'h0000, 1'b0);
        rd(16'h8123); rd(16'h4001); rd(16'hC200); rd(16'hC201); rd(16'hC202);
        rd(16'h0100); rd(16'h4410);

        // R8: unmatched neighbours return fixed ROM bytes
        cur_req = "R8";
        rd(16'h8122); rd(16'h8124); rd(16'hC203); rd(16'h4002);

        // R7: lowest index wins
        cur_req = "R7";
        step(16'h0000, 1'b0);
        wr(9, 1'b1, 16'h9000, 8'h77, 16'h0000, 1'b0);
        wr(3, 1'b1, 16'h9000, 8'h33, 16'h0000, 1'b0);
        rd(16'h9000);

        // R11: invalidating an entry exposes the next one, then the ROM
        cur_req = "R11";
        step(16'h0000, 1'b0);
        wr(3, 1'b0, 16'h9000, 8'h33, 16'h0000, 1'b0);
        rd(16'h9000);
        step(16'h0000, 1'b0);
        wr(9, 1'b0, 16'h9000, 8'h77, 16'h0000, 1'b0);
        rd(16'h9000);

        // R3: patch logic off
        cur_req = "R3";
        cfg_patch_off = 1'b1;
        rd(16'h4400); rd(16'h47FF); rd(16'h4001); rd(16'h8123); rd(16'hC200);
        cfg_patch_off = 1'b0;
        rd(16'h8123);

        // R9: second reset with a loaded table
        cur_req = "R9";
        step(16'h0000, 1'b0);
        do_reset();
        for (int i = 0; i < 16; i++) rd(16'h8123);
        rd(16'h8123); rd(16'hC200); rd(16'h4001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule